// File: doc/BRIEF.md
# Paged Memory Program Sequencer

This block sits on the host side of a byte-wide, page-organised, electrically erasable parallel memory and carries out one page program per request. A client supplies a start address, a byte count and, optionally, a request for the three-byte unlock prefix that such memories require when write protection is in force. The sequencer fetches each payload byte from a byte source port by index. It then strobes every byte onto the memory pins with parameterised setup, low-pulse and high-pulse times, all counted in clock cycles.

Once the last byte has been strobed, the sequencer releases its data bus and repeatedly reads back the last address written. While the memory is still busy, bit 7 of that read returns the complement of the value written. The write is finished when bit 7 matches the written value, and the sequencer then raises a one-cycle done pulse. If the bit never matches, a poll limit ends the attempt with a timeout pulse.

A request is refused up front when its count is outside 1..64 or when it would run past the end of its 64-byte page. A refused request issues no strobe.

Top module: `pgprog_seq`

## Requirements
- R1: Out of reset the memory pins are idle: write strobe high, output enable high, chip select high, host data bus not driven, and busy low.
- R2: A start request whose count is 0, above 64, or whose start offset within the page plus count exceeds 64 raises err_reject for one cycle in the cycle after the start. No write strobe is issued and busy stays low.
- R3: An accepted request issues one write strobe per payload byte, in order. Payload byte k goes to start address + k and carries the value the source returns for src_idx = k. All payload strobes share address bits 14..6.
- R4: With req_unlock set, exactly three strobes precede the payload: data AAh to address 5555h, data 55h to address 2AAAh, and data A0h to address 5555h, in that order.
- R5: Each write strobe is low for exactly T_WP cycles. Successive strobe falling edges are T_SU+T_WP+T_WH cycles apart. The address and data are presented before the strobe falls.
- R6: Output enable is never low while the write strobe is low. The host data bus is never driven while output enable is low.
- R7: The gap between successive write strobe falling edges within one request is always below WINDOW_CYC cycles.
- R8: After the last strobe, the sequencer performs read cycles at the last address written, with output enable low for T_OE cycles and then high for T_OEH cycles. It pulses done only after a read returns bit 7 equal to bit 7 of the last byte written.
- R9: If bit 7 never matches within POLL_LIMIT polling cycles, err_timeout pulses for one cycle, the sequencer returns to idle, and done does not pulse.
- R10: A start request made while busy is ignored. It does not alter the strobes of the running request and does not raise err_reject.
- R11: busy stays high from the cycle after an accepted start until the cycle in which done or err_timeout pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse, sampled while idle |
| req_addr | input | 15 | Start address of the load |
| req_count | input | 7 | Number of payload bytes (1..64 valid) |
| req_unlock | input | 1 | Emit the three-byte unlock prefix first |
| src_idx | output | 6 | Index of the payload byte requested from the source |
| src_data | input | 8 | Payload byte for src_idx, returned combinationally |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: write completion detected |
| err_reject | output | 1 | One-cycle pulse: request refused |
| err_timeout | output | 1 | One-cycle pulse: polling limit reached |
| mem_addr | output | 15 | Memory address pins |
| mem_dout | output | 8 | Data to the memory |
| mem_dout_en | output | 1 | Host drives the data bus |
| mem_d7_in | input | 1 | Bit 7 of the memory's read data |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ce_n | output | 1 | Chip select, active low |

## Verification
The hardest situation to reach is a poll that keeps seeing the complemented bit for many read cycles and then sees the true value. Reaching it needs a memory that stays busy well past the first read. The bench models the memory as a cycle-counted device that becomes busy on every strobe and inverts bit 7 of the last byte until a programmable delay expires. A stuck mode never clears, which drives the timeout path. Bit 7 values of both polarities are used so that a sequencer ignoring the polarity finishes early and is caught by a monitor that flags done while the model is still busy.

// File: rtl/pgprog_pkg.sv
package pgprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HIGH  = 3'd3,
    ST_PREAD = 3'd4,
    ST_PGAP  = 3'd5
  } pg_state_e;

  localparam int PREFIX_LEN = 3;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgprog_req_check.sv
module pgprog_req_check #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int PAGE_W     = 6,
  parameter int CNT_W      = 7
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count,
  output logic              req_ok
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] end_off;
  logic             cnt_ok;

  always_comb begin
    end_off = SUM_W'(start_addr[PAGE_W-1:0]) + SUM_W'(count);
    cnt_ok  = (count != '0) && (SUM_W'(count) <= SUM_W'(PAGE_BYTES));
    req_ok  = cnt_ok && (end_off <= SUM_W'(PAGE_BYTES));
  end

endmodule

// File: rtl/pgprog_byte_sel.sv
module pgprog_byte_sel
  import pgprog_pkg::*;
#(
  parameter int                         ADDR_W     = 15,
  parameter int                         DATA_W     = 8,
  parameter int                         PAGE_W     = 6,
  parameter int                         SEQ_W      = 7,
  parameter logic [3*ADDR_W-1:0]        UNLK_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [3*DATA_W-1:0]        UNLK_DATA  = {8'hAA, 8'h55, 8'hA0}
) (
  input  logic [SEQ_W-1:0]  seq_idx,
  input  logic              unlock,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [PAGE_W-1:0] src_idx,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_data,
  output logic              in_prefix
);
  logic [ADDR_W-1:0] pre_addr [PREFIX_LEN];
  logic [DATA_W-1:0] pre_data [PREFIX_LEN];
  logic [ADDR_W-1:0] cur_pre_addr;
  logic [DATA_W-1:0] cur_pre_data;

  // Unpack the prefix table; entry 0 is the most significant slice.
  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_prefix
    assign pre_addr[i] = UNLK_ADDRS[(PREFIX_LEN-1-i)*ADDR_W +: ADDR_W];
    assign pre_data[i] = UNLK_DATA[(PREFIX_LEN-1-i)*DATA_W +: DATA_W];
  end

  always_comb begin
    in_prefix = unlock && (seq_idx < SEQ_W'(PREFIX_LEN));
    src_idx   = unlock ? PAGE_W'(seq_idx - SEQ_W'(PREFIX_LEN)) : PAGE_W'(seq_idx);
    case (seq_idx[1:0])
      2'd0:    begin cur_pre_addr = pre_addr[0]; cur_pre_data = pre_data[0]; end
      2'd1:    begin cur_pre_addr = pre_addr[1]; cur_pre_data = pre_data[1]; end
      default: begin cur_pre_addr = pre_addr[2]; cur_pre_data = pre_data[2]; end
    endcase
    sel_addr = in_prefix ? cur_pre_addr : (base_addr + ADDR_W'(src_idx));
    sel_data = in_prefix ? cur_pre_data : src_data;
  end

endmodule

// File: rtl/pgprog_poll_timer.sv
module pgprog_poll_timer #(
  parameter int LIMIT = 1100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    expired = run && (cnt_q == CNT_W'(LIMIT - 1));
    if (!run)
      cnt_d = '0;
    else if (!expired)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: the polling counter never passes its limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LIMIT));

endmodule

// File: rtl/pgprog_seq.sv
module pgprog_seq
  import pgprog_pkg::*;
#(
  parameter int                  ADDR_W     = 15,
  parameter int                  DATA_W     = 8,
  parameter int                  PAGE_BYTES = 64,
  parameter int                  T_SU       = 2,
  parameter int                  T_WP       = 10,
  parameter int                  T_WH       = 5,
  parameter int                  T_OE       = 20,
  parameter int                  T_OEH      = 15,
  parameter int                  WINDOW_CYC = 15000,
  parameter int                  POLL_LIMIT = 1100000,
  parameter logic [3*ADDR_W-1:0] UNLK_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [3*DATA_W-1:0] UNLK_DATA  = {8'hAA, 8'h55, 8'hA0}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_start,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(PAGE_BYTES+1)-1:0] req_count,
  input  logic                          req_unlock,
  output logic [$clog2(PAGE_BYTES)-1:0] src_idx,
  input  logic [DATA_W-1:0]             src_data,
  output logic                          busy,
  output logic                          done,
  output logic                          err_reject,
  output logic                          err_timeout,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_dout,
  output logic                          mem_dout_en,
  input  logic                          mem_d7_in,
  output logic                          mem_we_n,
  output logic                          mem_oe_n,
  output logic                          mem_ce_n
);
  localparam int PAGE_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W   = $clog2(PAGE_BYTES + 1);
  localparam int SEQ_W   = $clog2(PAGE_BYTES + PREFIX_LEN + 1);
  localparam int TMR_MAX = max2(max2(max2(T_SU, T_WP), max2(T_WH, T_OE)), T_OEH);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int GAP_W   = $clog2(WINDOW_CYC + 1);

  // Parameter sanity: a full byte slot must fit the load window, and the
  // address needs one setup cycle after it is registered.
  if (T_SU + T_WP + T_WH >= WINDOW_CYC) begin : g_bad_window
    $error("byte slot does not fit the load window");
  end
  if (T_SU < 2 || T_WP < 1 || T_WH < 1 || T_OE < 1 || T_OEH < 1) begin : g_bad_timing
    $error("phase lengths too short");
  end

  pg_state_e         state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [SEQ_W-1:0]  idx_q, idx_d;
  logic [SEQ_W-1:0]  total_q, total_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              unlock_q, unlock_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              rej_q, rej_d;
  logic              tmo_q, tmo_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  logic              req_ok;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic              in_prefix;
  logic              poll_run;
  logic              poll_exp;
  logic [TMR_W-1:0]  phase_last;
  logic              tmr_end;
  logic              last_byte;

  pgprog_req_check #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
  ) u_check (
    .start_addr(req_addr),
    .count     (req_count),
    .req_ok    (req_ok)
  );

  pgprog_byte_sel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .SEQ_W(SEQ_W),
    .UNLK_ADDRS(UNLK_ADDRS), .UNLK_DATA(UNLK_DATA)
  ) u_sel (
    .seq_idx  (idx_q),
    .unlock   (unlock_q),
    .base_addr(base_q),
    .src_data (src_data),
    .src_idx  (src_idx),
    .sel_addr (sel_addr),
    .sel_data (sel_data),
    .in_prefix(in_prefix)
  );

  assign poll_run = (state_q == ST_PREAD) || (state_q == ST_PGAP);

  pgprog_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (poll_run),
    .expired(poll_exp)
  );

  // Length of the current phase, minus one.
  always_comb begin
    case (state_q)
      ST_SETUP: phase_last = TMR_W'(T_SU - 1);
      ST_PULSE: phase_last = TMR_W'(T_WP - 1);
      ST_HIGH:  phase_last = TMR_W'(T_WH - 1);
      ST_PREAD: phase_last = TMR_W'(T_OE - 1);
      ST_PGAP:  phase_last = TMR_W'(T_OEH - 1);
      default:  phase_last = '0;
    endcase
    tmr_end   = (tmr_q == phase_last);
    last_byte = (idx_q == total_q - 1'b1);
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_end ? '0 : tmr_q + 1'b1;
    idx_d    = idx_q;
    total_d  = total_q;
    base_d   = base_q;
    unlock_d = unlock_q;
    addr_d   = addr_q;
    data_d   = data_q;
    done_d   = 1'b0;
    rej_d    = 1'b0;
    tmo_d    = 1'b0;
    gap_d    = (gap_q == GAP_W'(WINDOW_CYC)) ? gap_q : gap_q + 1'b1;

    case (state_q)
      ST_IDLE: begin
        tmr_d = '0;
        gap_d = '0;
        if (req_start) begin
          if (req_ok) begin
            base_d   = req_addr;
            unlock_d = req_unlock;
            total_d  = SEQ_W'(req_count) + (req_unlock ? SEQ_W'(PREFIX_LEN) : '0);
            idx_d    = '0;
            state_d  = ST_SETUP;
          end else begin
            rej_d = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (tmr_q == '0) begin
          addr_d = sel_addr;
          data_d = sel_data;
        end
        if (tmr_end) begin
          state_d = ST_PULSE;
          gap_d   = '0;
        end
      end
      ST_PULSE: begin
        if (tmr_end) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (tmr_end) begin
          if (last_byte) begin
            state_d = ST_PREAD;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_SETUP;
          end
        end
      end
      ST_PREAD: begin
        if (poll_exp) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_end) begin
          if (mem_d7_in == data_q[DATA_W-1]) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_PGAP;
          end
        end
      end
      ST_PGAP: begin
        if (poll_exp) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_end) begin
          state_d = ST_PREAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      idx_q    <= '0;
      total_q  <= '0;
      base_q   <= '0;
      unlock_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
      tmo_q    <= 1'b0;
      gap_q    <= '0;
    end else begin
      state_q  <= state_d;
      tmr_q    <= tmr_d;
      idx_q    <= idx_d;
      total_q  <= total_d;
      base_q   <= base_d;
      unlock_q <= unlock_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      done_q   <= done_d;
      rej_q    <= rej_d;
      tmo_q    <= tmo_d;
      gap_q    <= gap_d;
    end
  end

  // Pin decode
  always_comb begin
    mem_addr    = addr_q;
    mem_dout    = data_q;
    mem_dout_en = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HIGH);
    mem_we_n    = (state_q != ST_PULSE);
    mem_oe_n    = (state_q != ST_PREAD);
    mem_ce_n    = (state_q == ST_IDLE);
    busy        = (state_q != ST_IDLE);
    done        = done_q;
    err_reject  = rej_q;
    err_timeout = tmo_q;
  end

  // R6: output enable stays high while the write strobe is low
  p_oe_high_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R6: host bus released whenever the memory may drive it
  p_bus_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en);

  // R5: a strobe rises only after T_WP low cycles
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($past(tmr_q) == TMR_W'(T_WP - 1)));

  // R7: strobe spacing stays inside the load window
  p_load_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (gap_q < GAP_W'(WINDOW_CYC)));

  // R3: payload strobes stay on the requested page
  p_same_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !in_prefix) |->
      (mem_addr[ADDR_W-1:PAGE_W] == base_q[ADDR_W-1:PAGE_W]));

  // R2: a refusal never coincides with activity
  p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_reject |-> (!busy && mem_we_n));

  // R9: completion and timeout are exclusive
  p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_timeout));

  // R10: a start while busy leaves the base address untouched
  p_base_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base_q));

endmodule

// File: tb/tb_pgprog_seq.sv
`timescale 1ns/1ps
module tb_pgprog_seq;
  localparam int T_SU = 2, T_WP = 10, T_WH = 5, T_OE = 4, T_OEH = 3;
  localparam int WINDOW = 15000, PLIM = 3000, WR_DELAY = 500;
  localparam int SLOT = T_SU + T_WP + T_WH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0;
  logic [14:0] req_addr = '0;
  logic [6:0] req_count = '0;
  logic req_unlock = 1'b0;
  logic [5:0] src_idx;
  logic [7:0] src_data;
  logic busy, done, err_reject, err_timeout;
  logic [14:0] mem_addr;
  logic [7:0] mem_dout;
  logic mem_dout_en, mem_d7_in, mem_we_n, mem_oe_n, mem_ce_n;

  logic [7:0] seed = 8'h00;
  bit stuck = 1'b0;
  bit stat_clr = 1'b0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign src_data = seed ^ {src_idx, 2'b01};

  pgprog_seq #(
    .T_SU(T_SU), .T_WP(T_WP), .T_WH(T_WH), .T_OE(T_OE), .T_OEH(T_OEH),
    .WINDOW_CYC(WINDOW), .POLL_LIMIT(PLIM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_count(req_count), .req_unlock(req_unlock), .src_idx(src_idx),
    .src_data(src_data), .busy(busy), .done(done), .err_reject(err_reject),
    .err_timeout(err_timeout), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_d7_in(mem_d7_in), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ce_n(mem_ce_n)
  );

  // Memory model: busy after every strobe, bit 7 inverted until it settles
  logic [14:0] log_addr [80];
  logic [7:0]  log_data [80];
  int nlog, low_run, min_low, max_low, fall_gap, min_gap, max_gap, nfall, npoll, bad_poll;
  int bcnt;
  logic we_d, oe_d, mbusy;
  logic [7:0] lastd;

  assign mem_d7_in = mbusy ? ~lastd[7] : lastd[7];

  always @(posedge clk) begin
    we_d <= mem_we_n;
    oe_d <= mem_oe_n;
    if (stat_clr) begin
      nlog <= 0; low_run <= 0; min_low <= 999999; max_low <= 0;
      fall_gap <= 0; min_gap <= 999999; max_gap <= 0; nfall <= 0;
      npoll <= 0; bad_poll <= 0; mbusy <= 1'b0; bcnt <= 0; lastd <= 8'h00;
    end else begin
      fall_gap <= fall_gap + 1;
      if (!mem_we_n) low_run <= low_run + 1;
      if (we_d && !mem_we_n) begin
        if (nfall > 0) begin
          if (fall_gap < min_gap) min_gap <= fall_gap;
          if (fall_gap > max_gap) max_gap <= fall_gap;
        end
        nfall <= nfall + 1;
        fall_gap <= 1;
      end
      if (!we_d && mem_we_n && !mem_ce_n) begin
        if (low_run < min_low) min_low <= low_run;
        if (low_run > max_low) max_low <= low_run;
        low_run <= 0;
        if (nlog < 80) begin
          log_addr[nlog] <= mem_addr;
          log_data[nlog] <= mem_dout;
        end
        nlog <= nlog + 1;
        lastd <= mem_dout;
        mbusy <= 1'b1;
        bcnt <= 0;
      end else if (mbusy && !stuck) begin
        bcnt <= bcnt + 1;
        if (bcnt == WR_DELAY - 1) mbusy <= 1'b0;
      end
      if (oe_d && !mem_oe_n) begin
        npoll <= npoll + 1;
        if (nlog == 0 || mem_addr != log_addr[nlog-1]) bad_poll <= bad_poll + 1;
      end
    end
  end

  int viol_oe, viol_bus, viol_early;
  always @(negedge clk) begin
    if (stat_clr) begin
      viol_oe <= 0; viol_bus <= 0; viol_early <= 0;
    end else begin
      if (!mem_we_n && !mem_oe_n) viol_oe <= viol_oe + 1;
      if (!mem_oe_n && mem_dout_en) viol_bus <= viol_bus + 1;
      if (!mem_we_n && !mem_dout_en) viol_bus <= viol_bus + 1;
      if (done && mbusy) viol_early <= viol_early + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one request; res: 0 done, 1 reject, 2 timeout, 3 hang
  int busy_gaps;
  task automatic run_req(input logic [14:0] a, input logic [6:0] c, input bit u,
                         input bit inject, output int res);
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    busy_gaps = 0;
    req_addr = a; req_count = c; req_unlock = u; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    res = 3;
    for (int i = 0; i < 20000; i++) begin
      if (done)        begin res = 0; break; end
      if (err_reject)  begin res = 1; break; end
      if (err_timeout) begin res = 2; break; end
      if (!busy) busy_gaps++;
      if (inject && i == 30) begin
        req_addr = 15'h003F; req_count = 7'd2; req_unlock = 1'b0; req_start = 1'b1;
      end else begin
        req_start = 1'b0;
      end
      @(negedge clk);
    end
    req_start = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] expd(input int k);
    return seed ^ {k[5:0], 2'b01};
  endfunction

  task automatic t_reset();
    chk(mem_we_n === 1'b1, "R1", "we_n", mem_we_n, 1);
    chk(mem_oe_n === 1'b1, "R1", "oe_n", mem_oe_n, 1);
    chk(mem_ce_n === 1'b1, "R1", "ce_n", mem_ce_n, 1);
    chk(mem_dout_en === 1'b0, "R1", "dout_en", mem_dout_en, 0);
    chk(busy === 1'b0, "R1", "busy", busy, 0);
  endtask

  task automatic t_single();
    int res;
    seed = 8'h80;
    run_req(15'h0123, 7'd1, 1'b0, 1'b0, res);
    chk(res == 0, "R8", "single byte completion", res, 0);
    chk(nlog == 1, "R3", "single strobe count", nlog, 1);
    chk(log_addr[0] == 15'h0123, "R3", "single addr", log_addr[0], 15'h0123);
    chk(log_data[0] == expd(0), "R3", "single data", log_data[0], expd(0));
    chk(npoll >= 2, "R8", "repeated poll reads", npoll, 2);
    chk(bad_poll == 0, "R8", "poll address", bad_poll, 0);
    chk(viol_early == 0, "R8", "done while memory busy", viol_early, 0);
    chk(busy_gaps == 0, "R11", "busy held", busy_gaps, 0);
  endtask

  task automatic t_page_unlock();
    int res, bad;
    seed = 8'h13;
    run_req(15'h0400, 7'd64, 1'b1, 1'b0, res);
    chk(res == 0, "R8", "page completion", res, 0);
    chk(nlog == 67, "R4", "strobe count with prefix", nlog, 67);
    chk(log_addr[0] == 15'h5555 && log_data[0] == 8'hAA, "R4", "prefix 1", log_data[0], 8'hAA);
    chk(log_addr[1] == 15'h2AAA && log_data[1] == 8'h55, "R4", "prefix 2", log_data[1], 8'h55);
    chk(log_addr[2] == 15'h5555 && log_data[2] == 8'hA0, "R4", "prefix 3", log_data[2], 8'hA0);
    bad = 0;
    for (int k = 0; k < 64; k++)
      if (log_addr[k+3] != 15'h0400 + 15'(k) || log_data[k+3] != expd(k)) bad++;
    chk(bad == 0, "R3", "payload order and data", bad, 0);
    chk(min_low == T_WP && max_low == T_WP, "R5", "strobe low width", min_low, T_WP);
    chk(min_gap == SLOT && max_gap == SLOT, "R5", "strobe spacing", max_gap, SLOT);
    chk(max_gap < WINDOW, "R7", "spacing below window", max_gap, WINDOW);
    chk(viol_oe == 0, "R6", "oe low during strobe", viol_oe, 0);
    chk(viol_bus == 0, "R6", "bus drive conflict", viol_bus, 0);
    chk(viol_early == 0, "R8", "done while memory busy", viol_early, 0);
    chk(busy_gaps == 0, "R11", "busy held", busy_gaps, 0);
  endtask

  task automatic t_reject();
    int res;
    run_req(15'h003F, 7'd2, 1'b0, 1'b0, res);
    chk(res == 1, "R2", "page crossing refused", res, 1);
    chk(nlog == 0, "R2", "no strobe on crossing", nlog, 0);
    run_req(15'h0200, 7'd0, 1'b1, 1'b0, res);
    chk(res == 1, "R2", "zero count refused", res, 1);
    chk(nlog == 0, "R2", "no strobe on zero", nlog, 0);
    run_req(15'h0200, 7'd65, 1'b0, 1'b0, res);
    chk(res == 1, "R2", "count 65 refused", res, 1);
    chk(busy === 1'b0 && nlog == 0, "R2", "idle after refusal", nlog, 0);
  endtask

  task automatic t_boundary();
    int res;
    seed = 8'h7E;
    run_req(15'h0730, 7'd16, 1'b0, 1'b0, res);
    chk(res == 0, "R2", "exact page end accepted", res, 0);
    chk(nlog == 16, "R3", "boundary strobe count", nlog, 16);
    chk(log_addr[15] == 15'h073F, "R3", "boundary last addr", log_addr[15], 15'h073F);
    chk(log_data[15] == expd(15), "R3", "boundary last data", log_data[15], expd(15));
  endtask

  task automatic t_timeout();
    int res;
    seed = 8'hC4;
    stuck = 1'b1;
    run_req(15'h1000, 7'd3, 1'b0, 1'b0, res);
    chk(res == 2, "R9", "timeout raised", res, 2);
    chk(busy === 1'b0, "R9", "idle after timeout", busy, 0);
    chk(npoll >= PLIM / (T_OE + T_OEH) - 1, "R9", "polled until limit", npoll, PLIM / (T_OE + T_OEH));
    stuck = 1'b0;
  endtask

  task automatic t_ignore();
    int res;
    seed = 8'h22;
    run_req(15'h0A00, 7'd4, 1'b0, 1'b1, res);
    chk(res == 0, "R10", "run completes despite start", res, 0);
    chk(nlog == 4, "R10", "strobe count unchanged", nlog, 4);
    chk(log_addr[3] == 15'h0A03, "R10", "addresses unchanged", log_addr[3], 15'h0A03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_page_unlock();
    t_reject();
    t_boundary();
    t_timeout();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule